// File: doc/BRIEF.md
# Shadow Address Remapping Unit

This unit sits in front of a memory controller and inspects every address that arrives from the system bus. Addresses in the lower half of the space are real memory and go through unchanged. Addresses with the top bit set lie in an otherwise unused shadow range. They are translated page by page into real physical addresses. The translated pages may be scattered in real memory, so the operating system can hand the processor one aligned, contiguous superpage made of pages that are not contiguous.

Up to seven region descriptors split the shadow space. Each descriptor gives the first shadow page of its region, the region's length in pages, where the region's slice starts in a shared frame table, and how many table entries it owns. All descriptors are compared in parallel. The chosen region's table entry supplies the physical frame, and the 12-bit page offset is kept. A configuration port loads descriptors and table entries. Every result appears a fixed two cycles after its request, and a new request may be presented on every cycle.

Top module: `srm_remap_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, out_valid, out_err and out_addr are all zero.
- R2: A request whose address bit 31 is 0 comes out with out_addr equal to the input address and out_err at 0.
- R3: A request whose bit 31 is 1 and whose page number (bits 31:12) lies in [start, start+span) of a valid descriptor is translated. out_addr bits 31:12 are the frame stored at table entry (table base + page number - start) modulo 64.
- R4: For every translated request, out_addr bits 11:0 equal the input bits 11:0.
- R5: Consecutive shadow pages of one region map independently, to whatever frames their table entries hold, including frames that are not contiguous.
- R6: A shadow request that lands inside a valid region but whose page index (page number - start) is at or above the region's table size sets out_err to 1 with out_addr at 0.
- R7: A shadow request that lands in no valid descriptor's range sets out_err to 1 with out_addr at 0. Descriptors written with the valid field at 0 never match.
- R8: When the ranges of several valid descriptors contain the page, the descriptor with the lowest number is used.
- R9: out_valid is exactly in_valid delayed by two clock edges. Back-to-back requests each produce their own result, and cycles without a request produce none.
- R10: A descriptor or table write changes the translation of requests made after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_addr | input | 32 | Bus address of the request |
| out_valid | output | 1 | Result present this cycle |
| out_addr | output | 32 | Translated or passed-through address; 0 on error |
| out_err | output | 1 | Shadow address had no translation |
| cfg_desc_we | input | 1 | Write one region descriptor |
| cfg_desc_sel | input | 3 | Descriptor number, 0 to 6 |
| cfg_desc_valid | input | 1 | Descriptor enable |
| cfg_desc_start | input | 20 | First shadow page number of the region |
| cfg_desc_span | input | 20 | Region length in pages |
| cfg_desc_base | input | 6 | First frame-table entry of the region |
| cfg_desc_size | input | 7 | Number of table entries owned by the region |
| cfg_tbl_we | input | 1 | Write one frame-table entry |
| cfg_tbl_idx | input | 6 | Frame-table entry number |
| cfg_tbl_frame | input | 20 | Physical frame number to store |

## Verification
A request sampled on one rising edge gives its result on the ports just after the second rising edge that follows. That holds for the pass-through path, the translated path and both error paths. The bench predicts each request on the edge where the request is taken and moves that prediction through two slots, one per edge. It compares the ports 1 ns after every edge, so each cycle checks either a due result or the absence of one. Configuration writes are kept clear of requests in flight, so the prediction and the table read see the same contents.

// File: rtl/srm_pkg.sv
package srm_pkg;
    localparam int ADDR_W      = 32;
    localparam int PAGE_BITS   = 12;
    localparam int PN_W        = ADDR_W - PAGE_BITS;
    localparam int TBL_DEPTH   = 64;
    localparam int TIDX_W      = $clog2(TBL_DEPTH);
    localparam int NUM_REGIONS = 7;

    typedef struct packed {
        logic              valid;
        logic [PN_W-1:0]   start_pn;
        logic [PN_W-1:0]   span;
        logic [TIDX_W-1:0] tbl_base;
        logic [TIDX_W:0]   tbl_size;
    } region_desc_t;
endpackage

// File: rtl/srm_desc_bank.sv
module srm_desc_bank
    import srm_pkg::*;
#(
    parameter int NREG = NUM_REGIONS,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [SEL_W-1:0]           sel,
    input  region_desc_t               wdesc,
    output region_desc_t [NREG-1:0]    descs
);
    region_desc_t [NREG-1:0] descs_d, descs_q;

    always_comb begin
        descs_d = descs_q;
        for (int i = 0; i < NREG; i++) begin
            if (we && sel == SEL_W'(i)) descs_d[i] = wdesc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) descs_q <= '0;
        else        descs_q <= descs_d;
    end

    assign descs = descs_q;
endmodule

// File: rtl/srm_region_match.sv
module srm_region_match
    import srm_pkg::*;
#(
    parameter int NREG = NUM_REGIONS
) (
    input  region_desc_t [NREG-1:0] descs,
    input  logic [PN_W-1:0]         pn,
    output logic                    hit,
    output logic                    in_table,
    output logic [TIDX_W-1:0]       tidx
);
    logic [NREG-1:0]   in_range;
    logic [NREG-1:0]   fits;
    logic [TIDX_W-1:0] idx [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [PN_W-1:0] off;
        assign off         = pn - descs[g].start_pn;
        assign in_range[g] = descs[g].valid && (pn >= descs[g].start_pn)
                             && (off < descs[g].span);
        assign fits[g]     = off < {{(PN_W-TIDX_W-1){1'b0}}, descs[g].tbl_size};
        assign idx[g]      = descs[g].tbl_base + off[TIDX_W-1:0];
    end

    // lowest-numbered region wins: it is assigned last
    always_comb begin
        hit      = 1'b0;
        in_table = 1'b0;
        tidx     = '0;
        for (int i = NREG-1; i >= 0; i--) begin
            if (in_range[i]) begin
                hit      = 1'b1;
                in_table = fits[i];
                tidx     = idx[i];
            end
        end
    end
endmodule

// File: rtl/srm_frame_table.sv
module srm_frame_table
    import srm_pkg::*;
#(
    parameter int DEPTH = TBL_DEPTH,
    parameter int FW    = PN_W,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [FW-1:0] wframe,
    input  logic [IW-1:0] ridx,
    output logic [FW-1:0] rframe
);
    logic [FW-1:0] mem_d [DEPTH];
    logic [FW-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[widx] = wframe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rframe = mem_q[ridx];
endmodule

// File: rtl/srm_remap_unit.sv
module srm_remap_unit
    import srm_pkg::*;
#(
    parameter int NREG = NUM_REGIONS,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_err,
    input  logic              cfg_desc_we,
    input  logic [SEL_W-1:0]  cfg_desc_sel,
    input  logic              cfg_desc_valid,
    input  logic [PN_W-1:0]   cfg_desc_start,
    input  logic [PN_W-1:0]   cfg_desc_span,
    input  logic [TIDX_W-1:0] cfg_desc_base,
    input  logic [TIDX_W:0]   cfg_desc_size,
    input  logic              cfg_tbl_we,
    input  logic [TIDX_W-1:0] cfg_tbl_idx,
    input  logic [PN_W-1:0]   cfg_tbl_frame
);
    typedef struct packed {
        logic              v;
        logic              shadow;
        logic              err;
        logic [TIDX_W-1:0] tidx;
        logic [ADDR_W-1:0] addr;
    } match_stage_t;

    typedef struct packed {
        logic              v;
        logic              err;
        logic [ADDR_W-1:0] addr;
    } out_stage_t;

    match_stage_t s1_d, s1_q;
    out_stage_t   s2_d, s2_q;

    region_desc_t [NREG-1:0] descs;
    region_desc_t            wdesc;
    logic                    hit, in_table;
    logic [TIDX_W-1:0]       tidx;
    logic [PN_W-1:0]         frame;

    assign wdesc = '{valid: cfg_desc_valid, start_pn: cfg_desc_start,
                     span: cfg_desc_span, tbl_base: cfg_desc_base,
                     tbl_size: cfg_desc_size};

    srm_desc_bank #(.NREG(NREG)) u_descs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_desc_we),
        .sel   (cfg_desc_sel),
        .wdesc (wdesc),
        .descs (descs)
    );

    srm_region_match #(.NREG(NREG)) u_match (
        .descs    (descs),
        .pn       (in_addr[ADDR_W-1:PAGE_BITS]),
        .hit      (hit),
        .in_table (in_table),
        .tidx     (tidx)
    );

    srm_frame_table #(.DEPTH(TBL_DEPTH), .FW(PN_W)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_tbl_we),
        .widx   (cfg_tbl_idx),
        .wframe (cfg_tbl_frame),
        .ridx   (s1_q.tidx),
        .rframe (frame)
    );

    always_comb begin
        // stage 1: descriptor search
        s1_d        = '0;
        s1_d.v      = in_valid;
        s1_d.addr   = in_addr;
        s1_d.shadow = in_addr[ADDR_W-1];
        s1_d.err    = in_addr[ADDR_W-1] && !(hit && in_table);
        s1_d.tidx   = tidx;

        // stage 2: table read and result formation
        s2_d = '0;
        if (s1_q.v) begin
            s2_d.v = 1'b1;
            if (!s1_q.shadow) begin
                s2_d.addr = s1_q.addr;
            end else if (s1_q.err) begin
                s2_d.err = 1'b1;
            end else begin
                s2_d.addr = {frame, s1_q.addr[PAGE_BITS-1:0]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_valid = s2_q.v;
    assign out_addr  = s2_q.addr;
    assign out_err   = s2_q.err;
endmodule

// File: rtl/srm_remap_checker.sv
module srm_remap_checker
    import srm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ADDR_W-1:0] in_addr,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_addr,
    input logic              out_err
);
    logic              v1, v2;
    logic [ADDR_W-1:0] a1, a2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1 <= 1'b0; v2 <= 1'b0; a1 <= '0; a2 <= '0;
        end else begin
            v1 <= in_valid; v2 <= v1; a1 <= in_addr; a2 <= a1;
        end
    end

    p_two_cycle_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v2);

    p_real_passthrough_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !a2[ADDR_W-1]) |-> (out_addr == a2 && !out_err));

    p_offset_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err) |-> (out_addr[PAGE_BITS-1:0] == a2[PAGE_BITS-1:0]));

    p_err_zero_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_valid && out_addr == '0));

    p_err_only_shadow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> a2[ADDR_W-1]);
endmodule

bind srm_remap_unit srm_remap_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_addr   (in_addr),
    .out_valid (out_valid),
    .out_addr  (out_addr),
    .out_err   (out_err)
);

// File: tb/srm_remap_unit_test.sv
module srm_remap_unit_test;
    import srm_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [31:0]       in_addr = '0;
    logic              out_valid;
    logic [31:0]       out_addr;
    logic              out_err;
    logic              cfg_desc_we = 1'b0;
    logic [2:0]        cfg_desc_sel = '0;
    logic              cfg_desc_valid = 1'b0;
    logic [19:0]       cfg_desc_start = '0;
    logic [19:0]       cfg_desc_span = '0;
    logic [5:0]        cfg_desc_base = '0;
    logic [6:0]        cfg_desc_size = '0;
    logic              cfg_tbl_we = 1'b0;
    logic [5:0]        cfg_tbl_idx = '0;
    logic [19:0]       cfg_tbl_frame = '0;

    always #2 clk = ~clk;

    srm_remap_unit uut (.*);

    typedef struct {
        bit          v;
        bit          e;
        logic [31:0] a;
        string       tag;
    } exp_t;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_tag = "R9";
    exp_t  p1, p2, nx;

    bit          m_v     [7];
    int unsigned m_start [7];
    int unsigned m_span  [7];
    int unsigned m_base  [7];
    int unsigned m_size  [7];
    logic [19:0] m_tbl   [64];

    function automatic exp_t predict(logic [31:0] a, string tag);
        exp_t        r;
        int unsigned pn, off;
        r.v = 1; r.e = 0; r.a = a; r.tag = tag;
        if (!a[31]) return r;
        pn = a[31:12];
        for (int k = 0; k < 7; k++) begin
            if (m_v[k] && pn >= m_start[k] && (pn - m_start[k]) < m_span[k]) begin
                off = pn - m_start[k];
                if (off < m_size[k]) r.a = {m_tbl[(m_base[k] + off) % 64], a[11:0]};
                else begin r.e = 1; r.a = 0; end
                return r;
            end
        end
        r.e = 1; r.a = 0;
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            p1.v = 0; p1.e = 0; p1.a = 0; p1.tag = "R1";
            p2 = p1;
        end else begin
            nx.v = 0; nx.e = 0; nx.a = 0; nx.tag = "R9";
            if (in_valid) nx = predict(in_addr, cur_tag);
            if (cfg_tbl_we) m_tbl[cfg_tbl_idx] = cfg_tbl_frame;
            if (cfg_desc_we) begin
                m_v[cfg_desc_sel]     = cfg_desc_valid;
                m_start[cfg_desc_sel] = cfg_desc_start;
                m_span[cfg_desc_sel]  = cfg_desc_span;
                m_base[cfg_desc_sel]  = cfg_desc_base;
                m_size[cfg_desc_sel]  = cfg_desc_size;
            end
            p2 = p1;
            p1 = nx;
            #1;
            n_cmp++;
            if (out_valid !== p2.v || (p2.v && (out_addr !== p2.a || out_err !== p2.e))) begin
                n_bad++;
                $display("FAIL %s: got v=%0b a=%h e=%0b, expected v=%0b a=%h e=%0b",
                         p2.tag, out_valid, out_addr, out_err, p2.v, p2.a, p2.e);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic req(input logic [31:0] a, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_addr  = a;
        cur_tag  = tag;
    endtask

    task automatic wdesc(input int sel, input bit v, input int unsigned st,
                         input int unsigned sp, input int unsigned bs, input int unsigned sz);
        @(negedge clk);
        in_valid       = 1'b0;
        cfg_desc_we    = 1'b1;
        cfg_desc_sel   = 3'(sel);
        cfg_desc_valid = v;
        cfg_desc_start = 20'(st);
        cfg_desc_span  = 20'(sp);
        cfg_desc_base  = 6'(bs);
        cfg_desc_size  = 7'(sz);
        @(negedge clk);
        cfg_desc_we    = 1'b0;
    endtask

    task automatic wtbl(input int idx, input int unsigned fr);
        @(negedge clk);
        in_valid      = 1'b0;
        cfg_tbl_we    = 1'b1;
        cfg_tbl_idx   = 6'(idx);
        cfg_tbl_frame = 20'(fr);
        @(negedge clk);
        cfg_tbl_we    = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) m_tbl[i] = '0;
        for (int i = 0; i < 7; i++) begin
            m_v[i] = 0; m_start[i] = 0; m_span[i] = 0; m_base[i] = 0; m_size[i] = 0;
        end
        repeat (4) @(negedge clk);
        // R1: outputs quiet during reset
        n_cmp++;
        if (out_valid !== 1'b0 || out_err !== 1'b0 || out_addr !== '0) begin
            n_bad++;
            $display("FAIL R1: got v=%0b a=%h e=%0b, expected v=0 a=00000000 e=0",
                     out_valid, out_addr, out_err);
        end
        rst_n = 1'b1;
        idle(2);

        // region 0: four scattered frames, span 8 pages, table holds 4
        wdesc(0, 1, 'h80240, 8, 0, 4);
        wtbl(0, 'h40138); wtbl(1, 'h20285); wtbl(2, 'h06155); wtbl(3, 'h04012);
        // region 1 and 2 overlap at 0x80300
        wdesc(1, 1, 'h80300, 16, 8, 16);
        for (int i = 0; i < 16; i++) wtbl(8 + i, 'h10000 + i * 3);
        wdesc(2, 1, 'h80300, 32, 24, 32);
        for (int i = 0; i < 32; i++) wtbl(24 + i, 'h7ff00 + i);
        // disabled descriptor over 0xA0000
        wdesc(6, 0, 'hA0000, 16, 56, 8);
        idle(2);

        req(32'h0000_4080, "R2");
        req(32'h7fff_ffff, "R2");
        req(32'h8024_0080, "R3");
        req(32'h8024_1abc, "R5");
        req(32'h8024_2000, "R5");
        req(32'h8024_3fff, "R4");
        req(32'h8024_4000, "R6");
        req(32'h8024_7123, "R6");
        idle(1);
        req(32'h9000_0123, "R7");
        req(32'hA000_3456, "R7");
        req(32'h8023_f000, "R7");
        req(32'h8030_1555, "R8");
        req(32'h8030_f001, "R8");
        req(32'h8031_8010, "R8");
        req(32'h8031_f000, "R8");
        req(32'h8032_0000, "R7");
        idle(2);

        for (int i = 0; i < 24; i++) begin
            req({12'h803, 8'(i), 12'(i * 7)}, "R9");
            if (i % 5 == 4) idle(1);
        end
        idle(3);

        // R10: reconfiguration affects later requests
        wtbl(1, 'h3abcd);
        idle(2);
        req(32'h8024_1fff, "R10");
        idle(3);
        wdesc(0, 0, 'h80240, 8, 0, 4);
        idle(2);
        req(32'h8024_0080, "R10");
        idle(4);

        done = 1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got no end of run, expected completion");
            finish_run();
        end
    end
endmodule